// File: doc/BRIEF.md
# Subtract-and-Branch Single-Instruction Core

This block is a tiny processor whose whole instruction set is one operation: subtract one memory word from another, store the difference, and branch when that difference is zero or negative. Code and data share one internal word-addressed memory. Every instruction takes three consecutive words. The first is the address of the subtrahend, the second is the address of the minuend, which also receives the result, and the third is the branch destination.

The core steps through a fixed seven-cycle sequence per instruction against a single-port synchronous memory: it fetches the three fields, reads both operands, writes the difference back and then chooses the next program counter. A taken branch to a destination whose top bit is set stops the core and raises `halted`. A debug port shares the memory port and takes it over only while the core is in reset or halted. A host uses it to load a program under reset, release reset, wait for `halted`, and then read the results back.

Larger operations come from sequences of this one instruction through a scratch word that holds zero. Subtracting a location from itself clears it. Subtracting the zero word from itself jumps unconditionally. Three instructions add one location into another.

Top module: `subneg_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter returns to 0 and `halted` goes low. After release, execution starts with the instruction at address 0.
- R2: Each instruction with fields (a, b, t) replaces Mem[b] with Mem[b] - Mem[a], truncated to DW bits in two's complement.
- R3: When the stored difference, read as signed, is zero or negative, the next instruction is fetched from the low AW bits of t.
- R4: When the stored difference is positive, the next instruction is at PC + 3, modulo the memory depth.
- R5: An instruction whose two operand addresses are equal leaves zero at that address and branches to t.
- R6: A taken branch whose t has bit DW-1 set stops the core with `halted` high. The core then stays halted and makes no further memory writes until reset.
- R7: A fall-through instruction does not halt, even if bit DW-1 of its t is set.
- R8: Every instruction takes exactly 7 clock cycles. A program that executes N instructions ending in a halting branch raises `halted` 7·N edges after the first edge at which `rst` is sampled low.
- R9: A debug write (`dbg_en` and `dbg_we` high at an edge) stores `dbg_wdata` at `dbg_addr` only while `rst` is high or the core is halted. It is ignored while the core runs.
- R10: A debug read (`dbg_en` high, `dbg_we` low at an edge, while in reset or halted) presents Mem[`dbg_addr`] on `dbg_rdata` after that edge.
- R11: The three-instruction sequence (x,z,·),(z,y,·),(z,z,·) with Mem[z]=0 leaves Mem[y]+Mem[x] in y and zero in z.
- R12: The instruction (z,z,t) with Mem[z]=0 jumps to t unconditionally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halted | output | 1 | High once the core has stopped |
| dbg_en | input | 1 | Debug access request |
| dbg_we | input | 1 | Debug write strobe, qualified by dbg_en |
| dbg_addr | input | AW | Debug word address |
| dbg_wdata | input | DW | Debug write data |
| dbg_rdata | output | DW | Memory read data, valid the cycle after a debug read |

## Verification
A single instruction runs over every ordered pair drawn from a set of edge operands: zero, ±1, ±2, the largest positive and negative words, and a mid value. The stored difference then separates wrap-around from plain subtraction. Two marker instructions, one at the fall-through address and one at the branch address, record which path was taken, so the zero/negative/positive decision is resolved at each sign boundary. The same pairs also drive the three-instruction addition. A decrement loop checks the seven-cycle instruction length over many iterations, and it tries a debug write mid-run that must have no effect. Separate short programs cover self-clearing, the unconditional jump and a non-halting fall-through with the stop bit set.

// File: rtl/subneg_core.sv
module subneg_core #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic          halted,
  input  logic          dbg_en,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {
    ST_FA, ST_FB, ST_FT, ST_RA, ST_RB, ST_WB, ST_UPD, ST_HALT
  } st_t;

  st_t           st;
  logic [AW-1:0] pc, a_ad, b_ad, tgt_lo;
  logic          tgt_stop;
  logic [DW-1:0] val_a, diff;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q;
  logic [AW-1:0] core_addr, mem_addr;
  logic [DW-1:0] mem_wd, sub_w;
  logic          mem_we, dbg_own, take;

  assign halted    = (st == ST_HALT);
  assign dbg_own   = dbg_en && (rst || halted);
  assign sub_w     = mem_q - val_a;
  assign take      = ($signed(diff) <= 0);
  assign mem_addr  = dbg_own ? dbg_addr : core_addr;
  assign mem_we    = dbg_own ? dbg_we : (st == ST_WB && !rst);
  assign mem_wd    = dbg_own ? dbg_wdata : sub_w;
  assign dbg_rdata = mem_q;

  always_comb begin
    case (st)
      ST_FA:   core_addr = pc;
      ST_FB:   core_addr = pc + AW'(1);
      ST_FT:   core_addr = pc + AW'(2);
      ST_RA:   core_addr = a_ad;
      ST_RB:   core_addr = b_ad;
      ST_WB:   core_addr = b_ad;
      default: core_addr = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wd;
    mem_q <= mem[mem_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_FA;
      pc <= '0;
    end else begin
      case (st)
        ST_FA: st <= ST_FB;
        ST_FB: begin a_ad <= mem_q[AW-1:0]; st <= ST_FT; end
        ST_FT: begin b_ad <= mem_q[AW-1:0]; st <= ST_RA; end
        ST_RA: begin
          tgt_lo   <= mem_q[AW-1:0];
          tgt_stop <= mem_q[DW-1];
          st       <= ST_RB;
        end
        ST_RB: begin val_a <= mem_q; st <= ST_WB; end
        ST_WB: begin diff <= sub_w; st <= ST_UPD; end
        ST_UPD: begin
          if (take && tgt_stop) st <= ST_HALT;
          else begin
            pc <= take ? tgt_lo : pc + AW'(3);
            st <= ST_FA;
          end
        end
        default: st <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/subneg_core_chk.sv
module subneg_core_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          halted,
  input logic          dbg_en,
  input logic          upd,
  input logic          wb,
  input logic          take,
  input logic          stop,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] tgt_lo,
  input logic [AW-1:0] b_ad,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!halted && pc == '0)); // R1
  AST_WRITE_TO_B: assert property (@(posedge clk) disable iff (rst)
    (wb && !halted) |-> (mem_we && mem_addr == b_ad)); // R2
  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (upd && take && !stop) |=> pc == $past(tgt_lo)); // R3
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (upd && !take) |=> (pc - $past(pc)) == AW'(3)); // R4
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R6
  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $past(upd && take && stop)); // R6
  AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (rst)
    (halted && !dbg_en) |-> !mem_we); // R6
  AST_DBG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!halted && mem_we) |-> wb); // R9
endmodule

bind subneg_core subneg_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .halted(halted), .dbg_en(dbg_en),
  .upd(st == ST_UPD), .wb(st == ST_WB), .take(take), .stop(tgt_stop),
  .pc(pc), .tgt_lo(tgt_lo), .b_ad(b_ad), .mem_addr(mem_addr), .mem_we(mem_we)
);

// File: tb/sim_subneg_core.sv
module sim_subneg_core;
  localparam int CLK_P = 10;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam logic [15:0] STOP = 16'h8000;

  logic clk = 0, rst = 1, halted;
  logic dbg_en = 0, dbg_we = 0;
  logic [AW-1:0] dbg_addr = '0;
  logic [DW-1:0] dbg_wdata = '0, dbg_rdata;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  subneg_core #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .halted(halted), .dbg_en(dbg_en), .dbg_we(dbg_we),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    dbg_en = 1; dbg_we = 1; dbg_addr = AW'(a); dbg_wdata = d;
    @(negedge clk);
    dbg_en = 0; dbg_we = 0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    dbg_en = 1; dbg_we = 0; dbg_addr = AW'(a);
    @(negedge clk);
    d = dbg_rdata;
    dbg_en = 0;
  endtask

  task automatic ins(input int at, input int a, input int b, input logic [15:0] t);
    wr(at, 16'(a)); wr(at + 1, 16'(b)); wr(at + 2, t);
  endtask

  task automatic enter_reset();
    @(negedge clk); rst = 1;
    @(negedge clk);
  endtask

  task automatic run(input int poke_at, output int cyc);
    @(negedge clk); rst = 0;
    cyc = 0;
    while (cyc < 5000) begin
      @(negedge clk);
      cyc++;
      dbg_en = 0; dbg_we = 0;
      if (halted) break;
      if (cyc == poke_at) begin
        dbg_en = 1; dbg_we = 1; dbg_addr = AW'(200); dbg_wdata = 16'h5A5A;
      end
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] vals [8];
    logic [15:0] r, r2, expv;
    int cyc;
    vals = '{16'd0, 16'd1, 16'hFFFF, 16'd2, 16'hFFFE, 16'h7FFF, 16'h8000, 16'd100};
    repeat (3) @(negedge clk);
    chk(halted == 0, "R1 halted low in reset", int'(halted), 0);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [15:0] res;
        bit tk;
        enter_reset();
        chk(halted == 0, "R1 reset clears halt", int'(halted), 0);
        ins(0, 10, 11, 16'd6);
        ins(3, 15, 13, STOP);
        ins(6, 15, 14, STOP);
        wr(10, vals[i]); wr(11, vals[j]); wr(13, 0); wr(14, 0); wr(15, 1);
        run(-1, cyc);
        res = vals[j] - vals[i];
        tk = ($signed(res) <= 0);
        chk(cyc == 14, "R8 two instructions cycles", cyc, 14);
        rd(11, r);
        chk(r == res, "R2 difference stored", int'(r), int'(res));
        rd(13, r); rd(14, r2);
        if (tk) begin
          chk(r == 0 && r2 == 16'hFFFF, "R3 branch taken on <=0", int'(r2), -1);
        end else begin
          chk(r == 16'hFFFF && r2 == 0, "R4 fall through on >0", int'(r), -1);
        end
      end
    end

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        enter_reset();
        ins(0, 20, 22, 16'd3);
        ins(3, 22, 21, 16'd6);
        ins(6, 22, 22, 16'd9);
        ins(9, 22, 22, STOP);
        wr(20, vals[i]); wr(21, vals[j]); wr(22, 0);
        run(-1, cyc);
        chk(cyc == 28, "R11 add sequence cycles", cyc, 28);
        expv = vals[j] + vals[i];
        rd(21, r);
        chk(r == expv, "R11 sum", int'(r), int'(expv));
        rd(22, r);
        chk(r == 0, "R11 scratch zero", int'(r), 0);
      end
    end

    enter_reset();
    ins(0, 40, 40, 16'd3);
    ins(3, 22, 22, STOP);
    wr(40, 16'd1234); wr(22, 0);
    run(-1, cyc);
    chk(cyc == 14 && halted, "R5 self clear reaches target", cyc, 14);
    rd(40, r);
    chk(r == 0, "R5 self clear value", int'(r), 0);
    repeat (10) @(negedge clk);
    chk(halted == 1, "R6 halt sticky", int'(halted), 1);
    rd(40, r); rd(22, r2);
    chk(r == 0 && r2 == 0, "R6 no writes after halt", int'(r), 0);

    enter_reset();
    ins(0, 22, 22, 16'd9);
    ins(3, 15, 13, STOP);
    ins(9, 22, 22, STOP);
    wr(22, 0); wr(15, 1); wr(13, 0);
    run(-1, cyc);
    rd(13, r);
    chk(cyc == 14 && r == 0, "R12 jump skips address 3", int'(r), 0);

    enter_reset();
    ins(0, 15, 30, 16'h8003);
    ins(3, 22, 22, STOP);
    wr(15, 1); wr(22, 0); wr(30, 5);
    run(-1, cyc);
    chk(cyc == 14, "R7 fall through with stop bit does not halt", cyc, 14);
    rd(30, r);
    chk(r == 4, "R7 result", int'(r), 4);

    enter_reset();
    ins(0, 15, 30, 16'd6);
    ins(3, 22, 22, 16'd0);
    ins(6, 22, 22, STOP);
    wr(15, 1); wr(22, 0); wr(30, 40); wr(200, 16'h1111);
    run(100, cyc);
    chk(cyc == 14 * 40, "R8 loop cycle count", cyc, 560);
    rd(30, r);
    chk(r == 0, "R3 loop exit value", int'(r), 0);
    rd(200, r);
    chk(r == 16'h1111, "R9 write while running ignored", int'(r), 16'h1111);
    wr(201, 16'hBEEF);
    rd(201, r);
    chk(r == 16'hBEEF, "R10 halted debug write/read", int'(r), 16'hBEEF);
    enter_reset();
    chk(halted == 0, "R1 reset after halt", int'(halted), 0);
    wr(202, 16'h0042);
    rd(202, r);
    chk(r == 16'h0042, "R9 write in reset accepted", int'(r), 16'h0042);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule